// File: doc/BRIEF.md
# Page-Splitting DMA Descriptor Generator

This block turns one transfer request into a chain of DMA descriptors. A request has a start address, a byte length and a direction. The block splits the buffer so that no descriptor crosses a memory page boundary. It then presents the descriptors one at a time on a valid/ready stream. Each descriptor carries a command code, a byte count and a physical address. Addresses pass through unchanged, so translation is identity. The chain always ends with a stop descriptor.

Segments follow a fixed pattern. If the start is unaligned, the first segment runs only to the next page boundary. Full-page segments follow. The final data segment uses a "last" command rather than a "more" command. A new request is taken only once the previous chain's stop descriptor has been handshaken. The page size is a parameter.

Top module: `dma_page_splitter`

## Requirements
- R1: While `rst_ni` is low and after reset is released, `desc_valid_o` and `busy_o` are 0 and `req_ready_o` is 1.
- R2: For an unaligned start whose length runs past the end of the first page, the first descriptor has count PAGE_BYTES minus (address mod PAGE_BYTES), a "more" command, and the start address.
- R3: While more than one page of data remains at a page-aligned address, the next descriptor has count exactly PAGE_BYTES and a "more" command. Each descriptor's address equals the start address plus the sum of earlier counts, and no data descriptor crosses a page boundary.
- R4: The final data descriptor has a "last" command and a count equal to the remaining bytes, which lies from 1 to PAGE_BYTES.
- R5: The 4-bit command code depends on direction. Writes (`req_read_i`=0) use 0 for more and 1 for last. Reads (`req_read_i`=1) use 2 for more and 3 for last.
- R6: Every chain ends with exactly one stop descriptor: command 7, count 0, address 0.
- R7: `desc_int_o`, `desc_wait_o` and `desc_branch_o` are each 2'b00, the "never" encoding, on every descriptor.
- R8: An unaligned request that ends at or before its first page boundary produces one "last" descriptor with the full length, then the stop descriptor.
- R9: A zero-length request produces only the stop descriptor.
- R10: While `desc_valid_o` is 1 and `desc_ready_i` is 0, all descriptor outputs hold their values and `desc_valid_o` stays 1 in the next cycle.
- R11: `busy_o` rises in the cycle after a request is accepted and falls in the cycle after the stop descriptor is handshaken. `req_ready_o` is low while busy, and requests offered while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request can be taken |
| req_addr_i | input | ADDR_W | Buffer start address |
| req_len_i | input | LEN_W | Buffer length in bytes |
| req_read_i | input | 1 | 1 = read (input commands), 0 = write |
| desc_valid_o | output | 1 | Descriptor presented |
| desc_ready_i | input | 1 | Descriptor taken by consumer |
| desc_cmd_o | output | 4 | Command code |
| desc_count_o | output | LEN_W | Byte count |
| desc_addr_o | output | ADDR_W | Physical address |
| desc_int_o | output | 2 | Interrupt control, always never |
| desc_wait_o | output | 2 | Wait control, always never |
| desc_branch_o | output | 2 | Branch control, always never |
| busy_o | output | 1 | Chain in progress |

## Verification
The bench targets several boundary cases:
- A start one byte before a page boundary: a design that splits in the wrong place would emit a descriptor that crosses the page.
- A buffer that exactly fills its first page, and one of exactly one page: an off-by-one in the last-segment test would emit an extra "more" descriptor or a zero-count descriptor.
- A zero-length request: a design that skips the length check would emit a data descriptor before the stop.

Random backpressure exposes descriptors that change while stalled. Requests offered mid-chain expose a design that accepts them while busy and corrupts the chain.

// File: rtl/dma_pgs_pkg.sv
package dma_pgs_pkg;
  typedef enum logic [3:0] {
    CMD_OUT_MORE = 4'd0,
    CMD_OUT_LAST = 4'd1,
    CMD_IN_MORE  = 4'd2,
    CMD_IN_LAST  = 4'd3,
    CMD_STOP     = 4'd7
  } dma_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_STOP = 2'd2
  } pgs_state_e;

  localparam logic [1:0] CTRL_NEVER = 2'b00;
endpackage

// File: rtl/dma_pgs_seg.sv
// Length and command of the segment at the current position.
module dma_pgs_seg
  import dma_pgs_pkg::*;
#(
  parameter int LEN_W      = 20,
  parameter int PAGE_BYTES = 4096,
  localparam int PG_W      = $clog2(PAGE_BYTES)
) (
  input  logic [PG_W-1:0]  pg_off_i,
  input  logic [LEN_W-1:0] rem_i,
  input  logic             read_i,
  output logic [LEN_W-1:0] seg_len_o,
  output logic             seg_last_o,
  output dma_cmd_e         seg_cmd_o
);
  logic [LEN_W-1:0] room;

  always_comb begin
    room       = LEN_W'(PAGE_BYTES) - LEN_W'(pg_off_i);
    seg_last_o = (rem_i <= room);
    seg_len_o  = seg_last_o ? rem_i : room;
    if (read_i) seg_cmd_o = seg_last_o ? CMD_IN_LAST : CMD_IN_MORE;
    else        seg_cmd_o = seg_last_o ? CMD_OUT_LAST : CMD_OUT_MORE;
  end
endmodule

// File: rtl/dma_pgs_ctrl.sv
// Chain state and position registers.
module dma_pgs_ctrl
  import dma_pgs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_fire_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_read_i,
  input  logic              desc_fire_i,
  input  logic [LEN_W-1:0]  seg_len_i,
  input  logic              seg_last_i,
  output pgs_state_e        state_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  rem_o,
  output logic              read_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      addr_o  <= '0;
      rem_o   <= '0;
      read_o  <= 1'b0;
    end else begin
      unique case (state_o)
        ST_IDLE: if (req_fire_i) begin
          addr_o  <= req_addr_i;
          rem_o   <= req_len_i;
          read_o  <= req_read_i;
          state_o <= (req_len_i == '0) ? ST_STOP : ST_DATA;
        end
        ST_DATA: if (desc_fire_i) begin
          addr_o <= addr_o + ADDR_W'(seg_len_i);
          rem_o  <= rem_o - seg_len_i;
          if (seg_last_i) state_o <= ST_STOP;
        end
        ST_STOP: if (desc_fire_i) state_o <= ST_IDLE;
        default: state_o <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_page_splitter.sv
module dma_page_splitter
  import dma_pgs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 20,
  parameter int PAGE_BYTES = 4096,
  localparam int PG_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_read_i,
  output logic              desc_valid_o,
  input  logic              desc_ready_i,
  output logic [3:0]        desc_cmd_o,
  output logic [LEN_W-1:0]  desc_count_o,
  output logic [ADDR_W-1:0] desc_addr_o,
  output logic [1:0]        desc_int_o,
  output logic [1:0]        desc_wait_o,
  output logic [1:0]        desc_branch_o,
  output logic              busy_o
);
  pgs_state_e        state;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic              read_q;
  logic [LEN_W-1:0]  seg_len;
  logic              seg_last;
  dma_cmd_e          seg_cmd;
  logic              req_fire, desc_fire;

  assign req_ready_o  = (state == ST_IDLE);
  assign desc_valid_o = (state != ST_IDLE);
  assign busy_o       = (state != ST_IDLE);
  assign req_fire     = req_valid_i && req_ready_o;
  assign desc_fire    = desc_valid_o && desc_ready_i;

  dma_pgs_seg #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) seg_i (
    .pg_off_i  (addr_q[PG_W-1:0]),
    .rem_i     (rem_q),
    .read_i    (read_q),
    .seg_len_o (seg_len),
    .seg_last_o(seg_last),
    .seg_cmd_o (seg_cmd)
  );

  dma_pgs_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_fire_i (req_fire),
    .req_addr_i (req_addr_i),
    .req_len_i  (req_len_i),
    .req_read_i (req_read_i),
    .desc_fire_i(desc_fire),
    .seg_len_i  (seg_len),
    .seg_last_i (seg_last),
    .state_o    (state),
    .addr_o     (addr_q),
    .rem_o      (rem_q),
    .read_o     (read_q)
  );

  always_comb begin
    if (state == ST_DATA) begin
      desc_cmd_o   = seg_cmd;
      desc_count_o = seg_len;
      desc_addr_o  = addr_q;
    end else begin
      desc_cmd_o   = CMD_STOP;
      desc_count_o = '0;
      desc_addr_o  = '0;
    end
  end

  assign desc_int_o    = CTRL_NEVER;
  assign desc_wait_o   = CTRL_NEVER;
  assign desc_branch_o = CTRL_NEVER;
endmodule

// File: rtl/dma_pgs_chk.sv
module dma_pgs_chk #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 20,
  parameter int PAGE_BYTES = 4096,
  localparam int PG_W      = $clog2(PAGE_BYTES),
  localparam int CW        = LEN_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              desc_valid_o,
  input logic              desc_ready_i,
  input logic [3:0]        desc_cmd_o,
  input logic [LEN_W-1:0]  desc_count_o,
  input logic [ADDR_W-1:0] desc_addr_o,
  input logic [1:0]        desc_int_o,
  input logic [1:0]        desc_wait_o,
  input logic [1:0]        desc_branch_o,
  input logic              busy_o
);
  logic is_stop;
  assign is_stop = (desc_cmd_o == 4'd7);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !desc_valid_o && req_ready_o);

  assert_no_page_cross_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && !is_stop |->
      desc_count_o != '0 &&
      (CW'(desc_addr_o[PG_W-1:0]) + CW'(desc_count_o)) <= CW'(PAGE_BYTES));

  assert_cmd_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> desc_cmd_o <= 4'd3 || is_stop);

  assert_stop_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && is_stop |-> desc_count_o == '0 && desc_addr_o == '0);

  assert_ctrl_never_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> desc_int_o == 2'b00 && desc_wait_o == 2'b00 && desc_branch_o == 2'b00);

  assert_hold_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && !desc_ready_i |=>
      desc_valid_o && $stable(desc_cmd_o) && $stable(desc_count_o) && $stable(desc_addr_o));

  assert_busy_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> busy_o);

  assert_busy_fall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && desc_ready_i && is_stop |=> !busy_o);
endmodule

bind dma_page_splitter dma_pgs_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
) chk_i (.*);

// File: tb/dma_page_splitter_tb_top.sv
module dma_page_splitter_tb_top;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 20;
  localparam int PAGE   = 4096;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [LEN_W-1:0]  req_len_i = '0;
  logic              req_read_i = 1'b0;
  logic              desc_valid_o;
  logic              desc_ready_i = 1'b0;
  logic [3:0]        desc_cmd_o;
  logic [LEN_W-1:0]  desc_count_o;
  logic [ADDR_W-1:0] desc_addr_o;
  logic [1:0]        desc_int_o, desc_wait_o, desc_branch_o;
  logic              busy_o;

  int total = 0;
  int fails = 0;
  bit done_all = 0;

  always #4 clk = ~clk;

  dma_page_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_len_i(req_len_i), .req_read_i(req_read_i),
    .desc_valid_o(desc_valid_o), .desc_ready_i(desc_ready_i),
    .desc_cmd_o(desc_cmd_o), .desc_count_o(desc_count_o), .desc_addr_o(desc_addr_o),
    .desc_int_o(desc_int_o), .desc_wait_o(desc_wait_o), .desc_branch_o(desc_branch_o),
    .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string msg);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  function automatic logic [3:0] exp_cmd(input bit rd, input bit last);
    return rd ? (last ? 4'd3 : 4'd2) : (last ? 4'd1 : 4'd0);
  endfunction

  task automatic run_chain(input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] len,
                           input bit rd, input int stall_pct);
    logic [ADDR_W-1:0] ea = a;
    longint            erem = len;
    int                idx = 0;
    bit                done = 0;
    bit                stalled = 0;
    logic [3:0]        s_cmd;
    logic [LEN_W-1:0]  s_cnt;
    logic [ADDR_W-1:0] s_adr;
    @(negedge clk);
    check(req_ready_o && !busy_o, $sformatf("R11 idle before request: ready=%0b busy=%0b exp 1/0",
          req_ready_o, busy_o));
    req_valid_i = 1'b1; req_addr_i = a; req_len_i = len; req_read_i = rd;
    @(negedge clk);
    check(busy_o && !req_ready_o, $sformatf("R11 busy after accept: busy=%0b ready=%0b exp 1/0",
          busy_o, req_ready_o));
    // offer a different request while busy; it must be ignored
    req_addr_i = ~a; req_len_i = len + LEN_W'(777); req_read_i = ~rd;
    for (int cyc = 0; cyc < 4000 && !done; cyc++) begin
      if (cyc != 0) @(negedge clk);
      if (stalled)
        check(desc_valid_o && desc_cmd_o == s_cmd && desc_count_o == s_cnt && desc_addr_o == s_adr,
              $sformatf("R10 stall hold: cmd=%0d cnt=%0d adr=%h exp %0d %0d %h",
                        desc_cmd_o, desc_count_o, desc_addr_o, s_cmd, s_cnt, s_adr));
      stalled = 0;
      if (!desc_valid_o) begin
        check(0, "R11 valid dropped mid-chain: valid=0 exp 1");
        break;
      end
      desc_ready_i = ($urandom_range(99) >= stall_pct);
      if (desc_ready_i) begin
        longint    room = PAGE - (ea % PAGE);
        bit        last = (erem <= room);
        logic [3:0] ec;
        longint    ecnt;
        logic [ADDR_W-1:0] eadr;
        string     tag;
        if (erem == 0) begin
          ec = 4'd7; ecnt = 0; eadr = '0; tag = (len == 0) ? "R9" : "R6";
        end else begin
          ec = exp_cmd(rd, last); ecnt = last ? erem : room; eadr = ea;
          if (last) tag = (idx == 0 && (a % PAGE) != 0) ? "R8/R5" : "R4/R5";
          else      tag = (idx == 0 && (a % PAGE) != 0) ? "R2/R5" : "R3/R5";
        end
        check(desc_cmd_o == ec && desc_count_o == LEN_W'(ecnt) && desc_addr_o == eadr,
              $sformatf("%s desc %0d: cmd=%0d cnt=%0d adr=%h exp %0d %0d %h", tag, idx,
                        desc_cmd_o, desc_count_o, desc_addr_o, ec, ecnt, eadr));
        check(desc_int_o == 2'b00 && desc_wait_o == 2'b00 && desc_branch_o == 2'b00,
              $sformatf("R7 ctrl fields: %b %b %b exp 00 00 00",
                        desc_int_o, desc_wait_o, desc_branch_o));
        if (erem == 0) begin
          done = 1;
          req_valid_i = 1'b0;
        end else begin
          ea = ea + ADDR_W'(ecnt);
          erem = erem - ecnt;
        end
        idx++;
      end else begin
        stalled = 1;
        s_cmd = desc_cmd_o; s_cnt = desc_count_o; s_adr = desc_addr_o;
      end
    end
    check(done, "R6 chain did not end with stop: done=0 exp 1");
    req_valid_i = 1'b0;
    @(negedge clk);
    desc_ready_i = 1'b0;
    check(!busy_o && req_ready_o && !desc_valid_o,
          $sformatf("R11 idle after stop: busy=%0b ready=%0b valid=%0b exp 0/1/0",
                    busy_o, req_ready_o, desc_valid_o));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(!desc_valid_o && !busy_o && req_ready_o,
          $sformatf("R1 in reset: valid=%0b busy=%0b ready=%0b exp 0/0/1",
                    desc_valid_o, busy_o, req_ready_o));
    rst_ni = 1'b1;
    @(negedge clk);
    check(!desc_valid_o && !busy_o && req_ready_o,
          $sformatf("R1 after reset: valid=%0b busy=%0b ready=%0b exp 0/0/1",
                    desc_valid_o, busy_o, req_ready_o));
    run_chain(32'h0000_1F00, 20'h300, 1'b1, 0);    // R2 split then last
    run_chain(32'h0000_2000, 20'h3000, 1'b0, 30);  // R3 three aligned pages
    run_chain(32'h0000_3010, 20'h100, 1'b1, 20);   // R8 fits in page
    run_chain(32'h0000_3F00, 20'h100, 1'b0, 0);    // R8 ends on boundary
    run_chain(32'h0000_5000, 20'h1000, 1'b1, 50);  // R4 exactly one page
    run_chain(32'h0000_4FFF, 20'h2, 1'b0, 0);      // R2 one byte before boundary
    run_chain(32'h0000_6123, 20'h0, 1'b1, 40);     // R9 zero length
    run_chain(32'h0000_7000, 20'h1, 1'b0, 0);      // R4 single byte
    for (int n = 0; n < 30; n++)
      run_chain($urandom, LEN_W'($urandom_range(5 * PAGE + 100)), 1'($urandom), 35);
    done_all = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_all) begin
      total++; fails++;
      $display("FAIL R11 watchdog expired: done=0 exp 1");
      summary();
      $finish;
    end
  end
endmodule